// File: doc/BRIEF.md
# Register-Triggered Expansion Bus Cycle Bridge

The bridge lets a host run one cycle at a time on an external expansion bus. It does this through four host-side register slots. The host first loads a page value (the upper address bits), a 16-bit low address and a 16-bit command word. It then writes the data slot, and that write starts the external cycle. For a write cycle, the value written to the data slot is the datum driven onto the bus. For a read cycle, the value written is a dummy. After the cycle ends, the host reads the data slot to get the datum captured from the bus. The command word chooses two things: the bus width (byte-wide or word-wide) and the cycle type (memory read, memory write, IO read, IO write, or bus reset). A status slot reports:

- whether a cycle is in progress;
- whether the last cycle timed out;
- a few echoed address and command bits, which a loopback test of the host path can read back.

The sequencing is done by one state machine with five states.

- `S_IDLE` waits for a trigger.
- `S_SETUP` holds the latched address and data for one cycle with no strobe active.
- `S_STROBE` raises the read or write strobe until the external acknowledge arrives or a fixed timeout runs out.
- `S_RSTPULSE` raises the bus reset line for a fixed number of cycles.
- `S_RECOVER` drops every strobe for one cycle before returning to `S_IDLE`.

The transitions are:

- idle→setup, on a data-slot write carrying a known command;
- setup→strobe, for read and write kinds;
- setup→rstpulse, for the reset kind;
- strobe→recover, on acknowledge or on timeout;
- rstpulse→recover, when the pulse count is reached;
- recover→idle, always.

Top module: `bus_cycle_bridge`

## Requirements
- R1: After reset, all bus strobes are low, ext_addr, ext_wdata and ext_word are 0, and host reads of slots 4, 5, 6 and 7 all return 0.
- R2: A host write to slot 6 loads the page (low PAGE_W bits), to slot 7 the 16-bit low address, to slot 4 the command word. Reads of slot 6 return the page zero-extended, slot 7 the low address, slot 5 the data register and slot 4 the status word.
- R3: A host write to slot 5 while idle, with a known command, sets busy (status bit 0) from the next cycle. One setup cycle then follows with no strobe. The strobe is then high until the edge at which ext_ack is sampled high, followed by one cycle with busy high and no strobe, after which busy clears.
- R4: The command word selects the cycle. Byte-wide: 0x0001 memory read, 0x0002 memory write, 0x0004 IO read, 0x0008 IO write. Word-wide: 0x8201 memory read, 0x8102 memory write, 0x8604 IO read, 0x8508 IO write. ext_word is high during word-wide cycles only.
- R5: During a write cycle, ext_wdata carries the value written to slot 5. A byte-wide cycle drives its upper byte as 0. The data register takes the same value.
- R6: After a read cycle, slot 5 returns the datum sampled from ext_rdata at the acknowledge edge. A word-wide cycle returns all 16 bits; a byte-wide cycle returns the low byte with the upper byte 0.
- R7: Command 0x0020 followed by a slot-5 write raises ext_bus_rst for exactly RST_LEN cycles without waiting for ext_ack. It leaves the data register unchanged.
- R8: Status word layout: bit 0 busy, bit 1 last-cycle timeout, bit 6 = low address bit 0, bit 8 = command bit 6, bit 9 = low address bit 8, bit 10 = page bit 0. All other bits are 0.
- R9: A slot-5 write while busy starts no cycle and leaves the data register unchanged.
- R10: IO cycles drive 0 on the page bits of ext_addr. Memory cycles drive {page, low address}.
- R11: Without ext_ack, the strobe stays high for exactly TIMEOUT cycles and then ends. A timed-out read loads all ones, masked to the cycle width. Status bit 1 is set and stays set until the next cycle starts.
- R12: A slot-5 write while the command register holds any other value starts no cycle and leaves the data register unchanged.
- R13: Writes to slots 4, 6 and 7 during a cycle change the registers but not the address, width or kind of the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the slot on host_addr |
| host_addr | input | 3 | Host slot index (4 status/command, 5 data, 6 page, 7 low address) |
| host_wdata | input | 16 | Host write value |
| host_rdata | output | 16 | Read value of the slot on host_addr (combinational) |
| ext_addr | output | PAGE_W+16 | External address, valid while a cycle runs |
| ext_wdata | output | 16 | External write datum |
| ext_rdata | input | 16 | External read datum |
| ext_word | output | 1 | High during word-wide cycles |
| ext_mem_rd | output | 1 | Memory read strobe |
| ext_mem_wr | output | 1 | Memory write strobe |
| ext_io_rd | output | 1 | IO read strobe |
| ext_io_wr | output | 1 | IO write strobe |
| ext_bus_rst | output | 1 | External bus reset pulse |
| ext_ack | input | 1 | External acknowledge, sampled while a strobe is high |

## Verification
The assertions assume that ext_ack and ext_rdata change only away from the rising edge. They also assume that ext_rdata is valid whenever ext_ack is high during a read strobe. The bench model of the external side meets both: it updates the acknowledge on the falling edge and derives the read datum from the current address. The timeout-bound property also relies on TIMEOUT being at least 1. The stimulus never applies a value outside the 3-bit host index. It produces acknowledge delays both below and above TIMEOUT, so both the acknowledge path and the timeout path out of S_STROBE are exercised.

// File: rtl/bcb_pkg.sv
package bcb_pkg;

    localparam logic [2:0] IDX_CMD  = 3'd4;
    localparam logic [2:0] IDX_DATA = 3'd5;
    localparam logic [2:0] IDX_PAGE = 3'd6;
    localparam logic [2:0] IDX_ADDR = 3'd7;

    localparam logic [15:0] CMD_B_MRD   = 16'h0001;
    localparam logic [15:0] CMD_B_MWR   = 16'h0002;
    localparam logic [15:0] CMD_B_IORD  = 16'h0004;
    localparam logic [15:0] CMD_B_IOWR  = 16'h0008;
    localparam logic [15:0] CMD_BUS_RST = 16'h0020;
    localparam logic [15:0] CMD_W_MRD   = 16'h8201;
    localparam logic [15:0] CMD_W_MWR   = 16'h8102;
    localparam logic [15:0] CMD_W_IORD  = 16'h8604;
    localparam logic [15:0] CMD_W_IOWR  = 16'h8508;

    typedef enum logic [2:0] {
        K_NONE,
        K_MEM_RD,
        K_MEM_WR,
        K_IO_RD,
        K_IO_WR,
        K_BUS_RST
    } cyc_kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_STROBE,
        S_RSTPULSE,
        S_RECOVER
    } fsm_state_t;

    typedef struct packed {
        cyc_kind_t kind;
        logic      wide;
    } cyc_sel_t;

    function automatic logic kind_is_read(input cyc_kind_t k);
        return (k == K_MEM_RD) || (k == K_IO_RD);
    endfunction

    function automatic logic kind_is_write(input cyc_kind_t k);
        return (k == K_MEM_WR) || (k == K_IO_WR);
    endfunction

    function automatic logic kind_is_io(input cyc_kind_t k);
        return (k == K_IO_RD) || (k == K_IO_WR);
    endfunction

    function automatic logic [15:0] fit_lane(input logic wide, input logic [15:0] v);
        return wide ? v : {8'h00, v[7:0]};
    endfunction

endpackage

// File: rtl/bcb_host_regs.sv
module bcb_host_regs
    import bcb_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [15:0]       wr_data,
    output logic [PAGE_W-1:0] page_q,
    output logic [15:0]       lo_q,
    output logic [15:0]       cmd_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            lo_q   <= '0;
            cmd_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_idx)
                IDX_CMD:  cmd_q  <= wr_data;
                IDX_PAGE: page_q <= wr_data[PAGE_W-1:0];
                IDX_ADDR: lo_q   <= wr_data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/bcb_cmd_decode.sv
module bcb_cmd_decode
    import bcb_pkg::*;
(
    input  logic [15:0] cmd,
    output cyc_sel_t    sel
);

    always_comb begin
        sel.kind = K_NONE;
        sel.wide = 1'b0;
        unique case (cmd)
            CMD_B_MRD:   sel.kind = K_MEM_RD;
            CMD_B_MWR:   sel.kind = K_MEM_WR;
            CMD_B_IORD:  sel.kind = K_IO_RD;
            CMD_B_IOWR:  sel.kind = K_IO_WR;
            CMD_BUS_RST: sel.kind = K_BUS_RST;
            CMD_W_MRD:   begin sel.kind = K_MEM_RD; sel.wide = 1'b1; end
            CMD_W_MWR:   begin sel.kind = K_MEM_WR; sel.wide = 1'b1; end
            CMD_W_IORD:  begin sel.kind = K_IO_RD;  sel.wide = 1'b1; end
            CMD_W_IOWR:  begin sel.kind = K_IO_WR;  sel.wide = 1'b1; end
            default:     ;
        endcase
    end

endmodule

// File: rtl/bcb_cycle_fsm.sv
module bcb_cycle_fsm
    import bcb_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter int TIMEOUT = 16,
    parameter int RST_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  cyc_sel_t            sel,
    input  logic [PAGE_W-1:0]   page,
    input  logic [15:0]         lo,
    input  logic [15:0]         wdata,
    input  logic                ext_ack,
    input  logic [15:0]         ext_rdata,
    output logic                busy,
    output logic                timed_out,
    output logic [15:0]         data_q,
    output logic [PAGE_W+15:0]  ext_addr,
    output logic [15:0]         ext_wdata,
    output logic                ext_word,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic                io_rd,
    output logic                io_wr,
    output logic                bus_rst
);

    localparam int ADDR_W = PAGE_W + 16;
    localparam int LIMIT  = (TIMEOUT > RST_LEN) ? TIMEOUT : RST_LEN;
    localparam int CNT_W  = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT - 1);
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_LEN - 1);

    fsm_state_t        state_q, state_d;
    cyc_kind_t         kind_q;
    logic              wide_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       wd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              to_q;
    logic [15:0]       data_r;
    logic              launch;
    logic              to_end;
    logic              rst_end;
    logic [ADDR_W-1:0] launch_addr;

    assign launch  = (state_q == S_IDLE) && start_req && (sel.kind != K_NONE);
    assign to_end  = (cnt_q == TO_LAST);
    assign rst_end = (cnt_q == RST_LAST);

    always_comb begin
        if (kind_is_io(sel.kind)) begin
            launch_addr = {{PAGE_W{1'b0}}, lo};
        end else if (sel.kind == K_BUS_RST) begin
            launch_addr = '0;
        end else begin
            launch_addr = {page, lo};
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (launch) state_d = S_SETUP;
            S_SETUP:    state_d = (kind_q == K_BUS_RST) ? S_RSTPULSE : S_STROBE;
            S_STROBE:   if (ext_ack || to_end) state_d = S_RECOVER;
            S_RSTPULSE: if (rst_end) state_d = S_RECOVER;
            S_RECOVER:  state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // cycle datapath: latched cycle description, counter, captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_NONE;
            wide_q <= 1'b0;
            addr_q <= '0;
            wd_q   <= '0;
            cnt_q  <= '0;
            to_q   <= 1'b0;
            data_r <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (launch) begin
                        kind_q <= sel.kind;
                        wide_q <= sel.wide;
                        addr_q <= launch_addr;
                        to_q   <= 1'b0;
                        if (kind_is_write(sel.kind)) begin
                            wd_q   <= fit_lane(sel.wide, wdata);
                            data_r <= fit_lane(sel.wide, wdata);
                        end else begin
                            wd_q <= '0;
                        end
                    end
                end
                S_SETUP: cnt_q <= '0;
                S_STROBE: begin
                    if (ext_ack) begin
                        if (kind_is_read(kind_q)) data_r <= fit_lane(wide_q, ext_rdata);
                    end else if (to_end) begin
                        to_q <= 1'b1;
                        if (kind_is_read(kind_q)) data_r <= fit_lane(wide_q, 16'hFFFF);
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_RSTPULSE: cnt_q <= cnt_q + 1'b1;
                S_RECOVER:  ;
                default:    ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        ext_addr  = busy ? addr_q : '0;
        ext_wdata = busy ? wd_q : '0;
        ext_word  = busy && wide_q;
        mem_rd    = (state_q == S_STROBE) && (kind_q == K_MEM_RD);
        mem_wr    = (state_q == S_STROBE) && (kind_q == K_MEM_WR);
        io_rd     = (state_q == S_STROBE) && (kind_q == K_IO_RD);
        io_wr     = (state_q == S_STROBE) && (kind_q == K_IO_WR);
        bus_rst   = (state_q == S_RSTPULSE);
        timed_out = to_q;
        data_q    = data_r;
    end

endmodule

// File: rtl/bus_cycle_bridge.sv
module bus_cycle_bridge
    import bcb_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter int TIMEOUT = 16,
    parameter int RST_LEN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [2:0]         host_addr,
    input  logic [15:0]        host_wdata,
    output logic [15:0]        host_rdata,
    output logic [PAGE_W+15:0] ext_addr,
    output logic [15:0]        ext_wdata,
    input  logic [15:0]        ext_rdata,
    output logic               ext_word,
    output logic               ext_mem_rd,
    output logic               ext_mem_wr,
    output logic               ext_io_rd,
    output logic               ext_io_wr,
    output logic               ext_bus_rst,
    input  logic               ext_ack
);

    logic [PAGE_W-1:0] page_q;
    logic [15:0]       lo_q;
    logic [15:0]       cmd_q;
    cyc_sel_t          sel;
    logic              busy;
    logic              timed_out;
    logic [15:0]       data_q;
    logic              start_req;
    logic [15:0]       status;

    assign start_req = host_wr && (host_addr == IDX_DATA);

    bcb_host_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr),
        .wr_idx  (host_addr),
        .wr_data (host_wdata),
        .page_q  (page_q),
        .lo_q    (lo_q),
        .cmd_q   (cmd_q)
    );

    bcb_cmd_decode u_dec (
        .cmd (cmd_q),
        .sel (sel)
    );

    bcb_cycle_fsm #(
        .PAGE_W  (PAGE_W),
        .TIMEOUT (TIMEOUT),
        .RST_LEN (RST_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .sel       (sel),
        .page      (page_q),
        .lo        (lo_q),
        .wdata     (host_wdata),
        .ext_ack   (ext_ack),
        .ext_rdata (ext_rdata),
        .busy      (busy),
        .timed_out (timed_out),
        .data_q    (data_q),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ext_word  (ext_word),
        .mem_rd    (ext_mem_rd),
        .mem_wr    (ext_mem_wr),
        .io_rd     (ext_io_rd),
        .io_wr     (ext_io_wr),
        .bus_rst   (ext_bus_rst)
    );

    always_comb begin
        status     = '0;
        status[0]  = busy;
        status[1]  = timed_out;
        status[6]  = lo_q[0];
        status[8]  = cmd_q[6];
        status[9]  = lo_q[8];
        status[10] = page_q[0];
    end

    always_comb begin
        unique case (host_addr)
            IDX_CMD:  host_rdata = status;
            IDX_DATA: host_rdata = data_q;
            IDX_PAGE: host_rdata = 16'(page_q);
            IDX_ADDR: host_rdata = lo_q;
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bcb_checker.sv
module bcb_checker #(
    parameter int PAGE_W  = 8,
    parameter int TIMEOUT = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic               io_rd,
    input logic               io_wr,
    input logic               bus_rst,
    input logic               ext_word,
    input logic               ext_ack,
    input logic [PAGE_W+15:0] ext_addr,
    input logic [7:0]         wdata_hi
);

    logic        hs;
    logic [31:0] run_q;

    assign hs = mem_rd | mem_wr | io_rd | io_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= hs ? run_q + 32'd1 : 32'd0;
    end

    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr, bus_rst}));

    p_strobe_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs || bus_rst) |-> busy);

    p_ack_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && ext_ack) |=> !hs);

    p_io_no_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> (ext_addr[PAGE_W+15:16] == '0));

    p_byte_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_wr || io_wr) && !ext_word) |-> (wdata_hi == 8'h00));

    p_addr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && $past(hs)) |-> $stable(ext_addr));

    p_timeout_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hs |-> (run_q < 32'(TIMEOUT)));

endmodule

bind bus_cycle_bridge bcb_checker #(
    .PAGE_W  (PAGE_W),
    .TIMEOUT (TIMEOUT)
) u_bcb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mem_rd   (ext_mem_rd),
    .mem_wr   (ext_mem_wr),
    .io_rd    (ext_io_rd),
    .io_wr    (ext_io_wr),
    .bus_rst  (ext_bus_rst),
    .ext_word (ext_word),
    .ext_ack  (ext_ack),
    .ext_addr (ext_addr),
    .wdata_hi (ext_wdata[15:8])
);

// File: tb/bus_cycle_bridge_test.sv
`timescale 1ns/1ps
module bus_cycle_bridge_test;

    localparam int TIMEOUT = 16;
    localparam int RST_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd4;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [23:0] ext_addr;
    logic [15:0] ext_wdata;
    logic [15:0] ext_rdata;
    logic        ext_word, ext_mem_rd, ext_mem_wr, ext_io_rd, ext_io_wr, ext_bus_rst;
    logic        ext_ack = 1'b0;

    int checks = 0;
    int bad = 0;
    int ack_delay = 1;
    int acnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_cycle_bridge #(.PAGE_W(8), .TIMEOUT(TIMEOUT), .RST_LEN(RST_LEN)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_word(ext_word),
        .ext_mem_rd(ext_mem_rd), .ext_mem_wr(ext_mem_wr), .ext_io_rd(ext_io_rd),
        .ext_io_wr(ext_io_wr), .ext_bus_rst(ext_bus_rst), .ext_ack(ext_ack)
    );

    function automatic logic [15:0] rd_fn(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], 8'h00} ^ 16'h5A3C;
    endfunction

    assign ext_rdata = rd_fn(ext_addr);

    // external responder: acknowledge after ack_delay strobe cycles
    always @(negedge clk) begin
        if (ext_mem_rd | ext_mem_wr | ext_io_rd | ext_io_wr) begin
            acnt = acnt + 1;
            ext_ack = (acnt >= ack_delay);
        end else begin
            acnt = 0;
            ext_ack = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int          m_phase = 0;   // 0 idle, 1 setup, 2 active, 3 recover
    int          m_kind = 0;    // 1 mrd 2 mwr 3 iord 4 iowr 5 reset
    bit          m_word = 0;
    int          m_cnt = 0;
    bit          m_to = 0;
    logic [23:0] m_addr = '0;
    logic [15:0] m_wd = '0;
    logic [15:0] m_data = '0;
    logic [7:0]  m_page = '0;
    logic [15:0] m_lo = '0;
    logic [15:0] m_cmd = '0;

    function automatic int m_decode(input logic [15:0] c, output bit w);
        w = 0;
        case (c)
            16'h0001: return 1;
            16'h0002: return 2;
            16'h0004: return 3;
            16'h0008: return 4;
            16'h0020: return 5;
            16'h8201: begin w = 1; return 1; end
            16'h8102: begin w = 1; return 2; end
            16'h8604: begin w = 1; return 3; end
            16'h8508: begin w = 1; return 4; end
            default:  return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_kind = 0; m_word = 0; m_cnt = 0; m_to = 0;
            m_addr = '0; m_wd = '0; m_data = '0; m_page = '0; m_lo = '0; m_cmd = '0;
        end else begin
            case (m_phase)
                0: if (host_wr && host_addr == 3'd5) begin
                    bit w;
                    int k;
                    k = m_decode(m_cmd, w);
                    if (k != 0) begin
                        m_phase = 1; m_kind = k; m_word = w; m_to = 0;
                        if (k == 3 || k == 4) m_addr = {8'h00, m_lo};
                        else if (k == 5)      m_addr = '0;
                        else                  m_addr = {m_page, m_lo};
                        if (k == 2 || k == 4) begin
                            m_wd = w ? host_wdata : {8'h00, host_wdata[7:0]};
                            m_data = m_wd;
                        end else begin
                            m_wd = '0;
                        end
                    end
                end
                1: begin m_phase = 2; m_cnt = 0; end
                2: begin
                    if (m_kind == 5) begin
                        if (m_cnt == RST_LEN - 1) m_phase = 3; else m_cnt++;
                    end else if (ext_ack) begin
                        m_phase = 3;
                        if (m_kind == 1 || m_kind == 3)
                            m_data = m_word ? ext_rdata : {8'h00, ext_rdata[7:0]};
                    end else if (m_cnt == TIMEOUT - 1) begin
                        m_phase = 3; m_to = 1;
                        if (m_kind == 1 || m_kind == 3)
                            m_data = m_word ? 16'hFFFF : 16'h00FF;
                    end else begin
                        m_cnt++;
                    end
                end
                default: m_phase = 0;
            endcase
            if (host_wr) begin
                case (host_addr)
                    3'd4: m_cmd = host_wdata;
                    3'd6: m_page = host_wdata[7:0];
                    3'd7: m_lo = host_wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison and strobe monitor
    int          strobe_cycles = 0;
    int          strobe_rises = 0;
    bit          prev_any = 0;
    logic [23:0] last_addr = '0;

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            logic [4:0]  exp_s;
            logic [15:0] exp_r;
            bit          any;
            exp_s = {m_phase == 2 && m_kind == 1, m_phase == 2 && m_kind == 2,
                     m_phase == 2 && m_kind == 3, m_phase == 2 && m_kind == 4,
                     m_phase == 2 && m_kind == 5};
            chk("R3 strobes", {27'd0, ext_mem_rd, ext_mem_wr, ext_io_rd, ext_io_wr, ext_bus_rst},
                {27'd0, exp_s});
            chk("R10 ext_addr", {8'd0, ext_addr}, {8'd0, (m_phase != 0) ? m_addr : 24'd0});
            chk("R5 ext_wdata", {16'd0, ext_wdata}, {16'd0, (m_phase != 0) ? m_wd : 16'd0});
            chk("R4 ext_word", {31'd0, ext_word}, {31'd0, (m_phase != 0) && m_word});
            case (host_addr)
                3'd4: exp_r = {5'd0, m_page[0], m_lo[8], m_cmd[6], 1'b0, m_lo[0], 4'd0, m_to, m_phase != 0};
                3'd5: exp_r = m_data;
                3'd6: exp_r = {8'd0, m_page};
                3'd7: exp_r = m_lo;
                default: exp_r = '0;
            endcase
            chk("R2 host_rdata", {16'd0, host_rdata}, {16'd0, exp_r});
            any = ext_mem_rd | ext_mem_wr | ext_io_rd | ext_io_wr | ext_bus_rst;
            if (any) begin strobe_cycles++; last_addr = ext_addr; end
            if (any && !prev_any) strobe_rises++;
            prev_any = any;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic hw(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 3'd4;
    endtask

    task automatic hr(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        host_addr = a;
        #1.5;
        chk(tag, {16'd0, host_rdata}, {16'd0, exp});
    endtask

    task automatic wait_idle();
        while (m_phase != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [15:0] cmd, input logic [15:0] d);
        hw(3'd4, cmd);
        strobe_cycles = 0; strobe_rises = 0;
        hw(3'd5, d);
        wait_idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        hr(3'd4, 16'h0000, "R1 status");
        hr(3'd5, 16'h0000, "R1 data");
        hr(3'd6, 16'h0000, "R1 page");
        hr(3'd7, 16'h0000, "R1 addr");
        chk("R1 strobes", {27'd0, ext_mem_rd, ext_mem_wr, ext_io_rd, ext_io_wr, ext_bus_rst}, 32'd0);

        // R2 register loading
        hw(3'd6, 16'hAB12);
        hw(3'd7, 16'h3456);
        hr(3'd6, 16'h0012, "R2 page readback");
        hr(3'd7, 16'h3456, "R2 addr readback");

        // R3 R6 byte memory read, ack after 2 strobe cycles
        ack_delay = 2;
        run(16'h0001, 16'hBEEF);
        chk("R3 strobe length", strobe_cycles, 2);
        chk("R6 last addr", {8'd0, last_addr}, 32'h123456);
        hr(3'd5, {8'h00, rd_fn(24'h123456) & 16'h00FF}, "R6 byte read");

        // R5 byte memory write
        ack_delay = 1;
        run(16'h0002, 16'hABCD);
        hr(3'd5, 16'h00CD, "R5 byte write data");

        // R10 IO read ignores page
        run(16'h0004, 16'h0000);
        chk("R10 io addr", {8'd0, last_addr}, 32'h003456);
        hr(3'd5, {8'h00, rd_fn(24'h003456) & 16'h00FF}, "R6 io byte read");
        run(16'h0008, 16'h1234);
        hr(3'd5, 16'h0034, "R4 io write data");

        // R4 word-wide commands
        ack_delay = 3;
        run(16'h8201, 16'h0000);
        chk("R3 word strobe length", strobe_cycles, 3);
        hr(3'd5, rd_fn(24'h123456), "R6 word read");
        run(16'h8102, 16'hCAFE);
        hr(3'd5, 16'hCAFE, "R5 word write");
        run(16'h8604, 16'h0000);
        hr(3'd5, rd_fn(24'h003456), "R4 word io read");
        run(16'h8508, 16'h7E81);
        hr(3'd5, 16'h7E81, "R4 word io write");

        // R7 bus reset
        run(16'h0020, 16'h5555);
        chk("R7 reset pulse length", strobe_cycles, RST_LEN);
        hr(3'd5, 16'h7E81, "R7 data unchanged");

        // R11 timeout
        hw(3'd6, 16'h0000);
        hw(3'd7, 16'h0000);
        ack_delay = 1000;
        run(16'h8201, 16'h0000);
        chk("R11 strobe length", strobe_cycles, TIMEOUT);
        hr(3'd5, 16'hFFFF, "R11 word timeout data");
        hr(3'd4, 16'h0002, "R11 timeout flag");
        run(16'h0001, 16'h0000);
        hr(3'd5, 16'h00FF, "R11 byte timeout data");
        ack_delay = 1;
        run(16'h0002, 16'h0042);
        hr(3'd4, 16'h0000, "R11 flag cleared");

        // R9 trigger while busy
        ack_delay = 4;
        hw(3'd4, 16'h8102);
        strobe_cycles = 0; strobe_rises = 0;
        hw(3'd5, 16'h1111);
        hw(3'd5, 16'h2222);
        wait_idle();
        chk("R9 one cycle", strobe_rises, 1);
        hr(3'd5, 16'h1111, "R9 data kept");

        // R13 register writes during a cycle
        hw(3'd6, 16'h0021);
        hw(3'd7, 16'h0F0F);
        hw(3'd4, 16'h8201);
        strobe_cycles = 0;
        hw(3'd5, 16'h0000);
        hw(3'd7, 16'h9999);
        hw(3'd6, 16'h0077);
        wait_idle();
        chk("R13 held addr", {8'd0, last_addr}, 32'h210F0F);
        hr(3'd5, rd_fn(24'h210F0F), "R13 read data");
        hr(3'd7, 16'h9999, "R13 addr register updated");

        // R12 unknown command
        hw(3'd4, 16'h0003);
        strobe_rises = 0;
        hw(3'd5, 16'h4444);
        repeat (6) @(negedge clk);
        chk("R12 no cycle", strobe_rises, 0);
        hr(3'd5, rd_fn(24'h210F0F), "R12 data kept");

        // R8 status echo bits
        hw(3'd6, 16'h0001);
        hw(3'd7, 16'h0101);
        hw(3'd4, 16'h0041);
        hr(3'd4, 16'h0740, "R8 status echo set");
        hw(3'd6, 16'h00FE);
        hw(3'd7, 16'hFEFE);
        hw(3'd4, 16'hFFBF);
        hr(3'd4, 16'h0000, "R8 status echo clear");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule